// File: doc/BRIEF.md
# Constant-On-Time Gate Sequencer

This block sequences the two gate enables of a synchronous buck power stage under constant-on-time control. It has no switching clock of its own. A new switching cycle starts only when the already-digitized feedback comparator reports that the output is below its reference. Each cycle drives the high-side gate for a programmed number of system-clock cycles. A minimum off interval then follows before the next cycle may begin. A valley over-current flag can hold off the next cycle.

A fixed dead interval always separates the two gates. Between pulses the low side either emulates a diode or runs as the complement of the high side. In the diode-emulating mode it turns off when the inductor current reaches zero. In the forced continuous mode it stays on until the next cycle. An undervoltage flag, a shutdown mode and two supervisor overrides (all gates off, low side held on) take precedence over normal sequencing. All timing is counted in system-clock cycles.

Top module: `cot_gate_seq`

## Requirements
- R1: During and right after reset both gate outputs are low.
- R2: Every high-side pulse lasts exactly the on-time count latched when its cycle started. A count of 0 is taken as 1, and changes to the count during a pulse have no effect on that pulse.
- R3: The high side stays low for at least MIN_OFF_CYC cycles between pulses. With demand held continuously, the low interval is exactly MIN_OFF_CYC + DEAD_CYC cycles.
- R4: While valley_oc is high no new cycle starts. Once it falls with demand present, the high side rises DEAD_CYC + 1 clock edges later.
- R5: In diode-emulation mode (mode = 2'b01), a zero_cross seen while the low side is on turns the low side off at the next edge. It stays off until the next cycle.
- R6: In forced continuous mode (mode = 2'b10), zero_cross is ignored and the low side stays on from the end of the dead interval until the next cycle begins.
- R7: The two gates are never high together. The low side rises exactly DEAD_CYC cycles after the high side falls. The high side rises no sooner than DEAD_CYC cycles after the low side falls.
- R8: Mode 2'b00 and mode 2'b11 both mean shutdown: both gates are low and demand starts no cycle.
- R9: When uvlo is high, both gates are low from the next clock edge on.
- R10: force_off drives both gates low at the next edge and overrides force_ls_on. force_ls_on turns the high side off, raises the low side DEAD_CYC + 1 edges later from idle, holds it on regardless of zero_cross and demand, and starts no cycle.
- R11: Without fb_low no cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_low | input | 1 | Feedback below reference (cycle demand) |
| valley_oc | input | 1 | Valley current above limit |
| zero_cross | input | 1 | Inductor current reached zero |
| mode | input | 2 | 00/11 shutdown, 01 diode emulation, 10 forced continuous |
| uvlo | input | 1 | Undervoltage lockout active |
| force_off | input | 1 | Supervisor: both gates off |
| force_ls_on | input | 1 | Supervisor: hold low side on |
| ton_cycles | input | TON_W | On-time in clock cycles |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
A demand sampled at one edge raises the high side DEAD_CYC edges after that decision edge. The pulse then lasts the latched count, and the low side follows DEAD_CYC cycles after the fall. Shutdown, uvlo, force_off and zero_cross act at the very next edge, while force_ls_on from idle takes DEAD_CYC + 1 edges. The bench drives inputs just after the falling edge and samples there too, so every expected level lands on a whole number of edges. A scoreboard queue holds the expected pulse widths and is compared at each high-side fall, and the dead and off gaps are measured as counts of sampled cycles.

// File: rtl/cot_gate_seq.sv
module cot_gate_seq #(
  parameter int TON_W       = 10,
  parameter int DEAD_CYC    = 6,
  parameter int MIN_OFF_CYC = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fb_low,
  input  logic             valley_oc,
  input  logic             zero_cross,
  input  logic [1:0]       mode,
  input  logic             uvlo,
  input  logic             force_off,
  input  logic             force_ls_on,
  input  logic [TON_W-1:0] ton_cycles,
  output logic             hs_gate,
  output logic             ls_gate
);
  localparam logic [1:0] MODE_DEM = 2'b01;
  localparam logic [1:0] MODE_CCM = 2'b10;
  localparam int DW      = $clog2(DEAD_CYC + 1);
  localparam int TW      = (TON_W > DW) ? TON_W : DW;
  localparam int OW      = $clog2(MIN_OFF_CYC + 1);
  localparam int GAP_MAX = MIN_OFF_CYC + DEAD_CYC;
  localparam int GW      = $clog2(GAP_MAX + 1);

  typedef enum logic [2:0] {S_OFF, S_DH, S_HS, S_DL, S_LS} st_t;

  st_t              st, st_n;
  logic [TW-1:0]    tmr;
  logic [TON_W-1:0] ton_lat;
  logic [OW-1:0]    moff;

  wire enabled   = !uvlo && (mode == MODE_DEM || mode == MODE_CCM);
  wire dem       = (mode == MODE_DEM);
  wire moff_done = (moff == OW'(MIN_OFF_CYC));
  wire tmr_zero  = (tmr == '0);
  wire start_ok  = fb_low && !valley_oc && moff_done && !force_off && !force_ls_on;

  always_comb begin
    st_n = st;
    if (!enabled || force_off) st_n = S_OFF;
    else if (force_ls_on) begin
      case (st)
        S_DL:    if (tmr_zero) st_n = S_LS;
        S_LS:    st_n = S_LS;
        default: st_n = S_DL;
      endcase
    end else begin
      case (st)
        S_OFF:   if (start_ok) st_n = S_DH;
        S_DH:    if (tmr_zero) st_n = S_HS;
        S_HS:    if (tmr_zero) st_n = S_DL;
        S_DL:    if (tmr_zero) st_n = S_LS;
        S_LS:    if (start_ok) st_n = S_DH;
                 else if (dem && zero_cross) st_n = S_OFF;
        default: st_n = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_OFF;
      tmr     <= '0;
      ton_lat <= TON_W'(1);
    end else begin
      st <= st_n;
      if (st_n != st) begin
        case (st_n)
          S_DH, S_DL: tmr <= TW'(DEAD_CYC - 1);
          S_HS:       tmr <= TW'(ton_lat) - TW'(1);
          default:    tmr <= '0;
        endcase
      end else if (!tmr_zero) begin
        tmr <= tmr - TW'(1);
      end
      if (st_n == S_DH && st != S_DH)
        ton_lat <= (ton_cycles == '0) ? TON_W'(1) : ton_cycles;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              moff <= OW'(MIN_OFF_CYC);
    else if (st == S_HS)     moff <= OW'(1);
    else if (!moff_done)     moff <= moff + OW'(1);
  end

  assign hs_gate = (st == S_HS);
  assign ls_gate = (st == S_LS);

  logic [GW-1:0] hs_low_cnt, ls_low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_low_cnt <= GW'(GAP_MAX);
      ls_low_cnt <= GW'(GAP_MAX);
    end else begin
      if (hs_gate) hs_low_cnt <= '0;
      else if (hs_low_cnt != GW'(GAP_MAX)) hs_low_cnt <= hs_low_cnt + GW'(1);
      if (ls_gate) ls_low_cnt <= '0;
      else if (ls_low_cnt != GW'(GAP_MAX)) ls_low_cnt <= ls_low_cnt + GW'(1);
    end
  end

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));
  // R7
  ls_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> hs_low_cnt >= GW'(DEAD_CYC));
  // R7
  hs_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> ls_low_cnt >= GW'(DEAD_CYC));
  // R3
  min_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> hs_low_cnt >= GW'(MIN_OFF_CYC));
  // R9
  uvlo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (!hs_gate && !ls_gate));
  // R10
  force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |=> (!hs_gate && !ls_gate));
  // R4 R11
  valley_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DH && $past(st) != S_DH) |-> $past(fb_low && !valley_oc));
  // R5
  zc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dem && zero_cross && ls_gate && !force_ls_on && !fb_low) |=> !ls_gate);
endmodule

// File: tb/cot_gate_seq_bench.sv
`timescale 1ns/1ps
module cot_gate_seq_bench;
  localparam int TON_W = 10, DEAD = 6, MOFF = 80;

  logic clk = 0, rst_n = 0, fb_low = 0, valley_oc = 0, zero_cross = 0;
  logic uvlo = 0, force_off = 0, force_ls_on = 0;
  logic [1:0] mode = 2'b01;
  logic [TON_W-1:0] ton = 10;
  logic hs, ls;

  cot_gate_seq #(.TON_W(TON_W), .DEAD_CYC(DEAD), .MIN_OFF_CYC(MOFF)) u_cot_gate_seq (
    .clk(clk), .rst_n(rst_n), .fb_low(fb_low), .valley_oc(valley_oc),
    .zero_cross(zero_cross), .mode(mode), .uvlo(uvlo), .force_off(force_off),
    .force_ls_on(force_ls_on), .ton_cycles(ton), .hs_gate(hs), .ls_gate(ls));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int exp_q[$];
  int hs_len = 0, hs_low = 1000, ls_low = 1000, rises = 0, last_gap = -1, last_dead = -1;
  int overlaps = 0, exp_w = 0, r0 = 0;
  bit hs_p = 0, ls_p = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse(int t);
    ton = TON_W'(t);
    exp_q.push_back(t);
    fb_low = 1;
    step(1);
    fb_low = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      hs_p = 0; ls_p = 0; hs_len = 0;
    end else begin
      if (hs && ls) overlaps++;
      if (hs && !hs_p) begin
        rises++;
        last_gap = hs_low;
        check(ls_low >= DEAD, "R7 low-side off to high-side on", ls_low, DEAD);
        hs_len = 0;
      end
      if (!hs && hs_p) begin
        if (exp_q.size() == 0) check(0, "R2 unexpected pulse", hs_len, -1);
        else begin
          exp_w = exp_q.pop_front();
          check(hs_len == exp_w, "R2 on-time width", hs_len, exp_w);
        end
      end
      if (ls && !ls_p) begin
        last_dead = hs_low;
        check(hs_low >= DEAD, "R7 high-side off to low-side on", hs_low, DEAD);
      end
      if (hs) begin hs_len++; hs_low = 0; end else hs_low++;
      if (ls) ls_low = 0; else ls_low++;
      hs_p = hs; ls_p = ls;
    end
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    step(3);
    check(!hs && !ls, "R1 gates low in reset", {hs, ls}, 0);
    rst_n = 1;
    step(2);
    check(!hs && !ls, "R1 gates low after reset", {hs, ls}, 0);

    // R2 R5 R7 diode emulation
    mode = 2'b01;
    step(5);
    pulse(20);
    step(2*DEAD + 23);
    check(ls == 1, "R5 low side on after pulse", ls, 1);
    check(last_dead == DEAD, "R7 exact dead before low side", last_dead, DEAD);
    zero_cross = 1;
    step(1);
    zero_cross = 0;
    check(ls == 0, "R5 zero crossing ends low side", ls, 0);
    step(30);
    check(!ls && !hs, "R5 low side stays off", {hs, ls}, 0);
    step(100);

    // R2 count latched at cycle start
    ton = 30;
    exp_q.push_back(30);
    fb_low = 1; step(1); fb_low = 0;
    step(DEAD + 5);
    ton = 5;
    step(120);
    pulse(0);
    exp_q[exp_q.size()-1] = 1;
    step(120);

    // R3 back-to-back pulses
    r0 = rises;
    ton = 10;
    repeat (3) exp_q.push_back(10);
    fb_low = 1;
    for (int i = 0; i < 2000 && rises < r0 + 3; i++) step(1);
    fb_low = 0;
    check(rises == r0 + 3, "R3 pulses under held demand", rises - r0, 3);
    check(last_gap == MOFF + DEAD, "R3 off interval under held demand", last_gap, MOFF + DEAD);
    step(150);

    // R6 forced continuous
    mode = 2'b10;
    step(2);
    pulse(15);
    step(2*DEAD + 18);
    zero_cross = 1;
    step(3);
    check(ls == 1, "R6 zero crossing ignored", ls, 1);
    step(40);
    check(ls == 1, "R6 low side held until next cycle", ls, 1);
    zero_cross = 0;
    step(100);

    // R4 valley limit
    r0 = rises;
    valley_oc = 1;
    fb_low = 1;
    step(200);
    check(rises == r0, "R4 no cycle while valley high", rises - r0, 0);
    check(ls == 1, "R4 low side kept on during valley hold", ls, 1);
    ton = 12;
    exp_q.push_back(12);
    valley_oc = 0;
    step(DEAD);
    check(hs == 0, "R4 high side still low before dead ends", hs, 0);
    step(1);
    check(hs == 1, "R4 high side on after release", hs, 1);
    fb_low = 0;
    step(120);

    // R11 no demand
    r0 = rises;
    step(300);
    check(rises == r0, "R11 no cycle without demand", rises - r0, 0);

    // R8 shutdown encodings
    mode = 2'b00;
    fb_low = 1;
    step(1);
    check(!hs && !ls, "R8 shutdown forces gates low", {hs, ls}, 0);
    step(200);
    check(rises == r0, "R8 no cycle in mode 00", rises - r0, 0);
    mode = 2'b11;
    step(200);
    check(rises == r0 && !ls, "R8 no cycle in mode 11", rises - r0, 0);
    fb_low = 0;
    mode = 2'b01;
    step(100);

    // R9 undervoltage during a pulse
    ton = 50;
    exp_q.push_back(11);
    fb_low = 1; step(1); fb_low = 0;
    for (int i = 0; i < 100 && !hs; i++) step(1);
    step(10);
    uvlo = 1;
    step(1);
    check(!hs && !ls, "R9 uvlo drops gates", {hs, ls}, 0);
    fb_low = 1;
    step(20);
    check(!hs && !ls, "R9 gates held low in uvlo", {hs, ls}, 0);
    fb_low = 0;
    uvlo = 0;
    step(100);

    // R10 overrides
    force_ls_on = 1;
    step(DEAD);
    check(ls == 0, "R10 low side waits dead interval", ls, 0);
    step(1);
    check(ls == 1, "R10 low side forced on", ls, 1);
    r0 = rises;
    zero_cross = 1;
    fb_low = 1;
    step(20);
    check(ls == 1 && rises == r0, "R10 forced low side held", rises - r0, 0);
    force_off = 1;
    step(1);
    check(!hs && !ls, "R10 force_off wins", {hs, ls}, 0);
    force_off = 0; force_ls_on = 0; zero_cross = 0; fb_low = 0;
    step(100);

    check(overlaps == 0, "R7 gates never overlap", overlaps, 0);
    check(exp_q.size() == 0, "R2 all expected pulses seen", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule